// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table in memory. Pages are 4 KiB, each table holds 1024 entries of 4 bytes, and a leaf found in the upper table maps a 4 MiB superpage. A request carries the virtual address, the access kind (fetch, load or store), whether the requester runs in supervisor or user mode, the supervisor-may-touch-user-pages flag, the make-executable-readable flag, a translation enable, and the page number of the root table.

The walker reads one entry at a time through a single-outstanding read port. It checks the privilege rule of the user bit, the entry format, the permission for the access kind and the superpage alignment. A successful walk sets the accessed bit, and for a store also the dirty bit, with one write of the whole entry, and only when a bit has to change. The result is a physical address or a fault. A fault is a page fault or an access fault, together with the access kind and the faulting virtual address.

Top module: `ptw_walker`

## Requirements
- R1: With translation disabled, the response comes on the clock after acceptance, without a fault, with the physical address equal to the virtual address zero-extended to 34 bits, and with no memory read.
- R2: The first read goes to root_ppn*4096 + 4*va[31:22]. A read after a pointer entry goes to next_ppn*4096 + 4*va[21:12]. Entry layout: V bit 0, R bit 1, W bit 2, X bit 3, U bit 4, A bit 6, D bit 7, page number in bits 31:10.
- R3: An entry with V set and R, W and X all clear points to the next table. Such an entry found in the lower table gives a page fault.
- R4: A read answered with an error gives an access fault (cause bit 2 clear), whether it is the first read or the second.
- R5: A leaf with U set faults in supervisor mode when the access is a fetch, or when the supervisor-user flag is clear. A leaf with U clear faults in user mode.
- R6: A leaf with V clear, or with W set and R clear, gives a page fault.
- R7: A fetch needs X. A load needs R, or needs X when the make-executable-readable flag is set. A store needs both R and W. Any missing permission gives a page fault.
- R8: A leaf in the upper table whose page number bits 9:0 are not zero gives a page fault.
- R9: On success the entry is written back with A set, and D also set for a store. The write happens only when a bit changes, and the response follows the write acknowledge.
- R10: A lower-table leaf gives {ppn, va[11:0]}. An upper-table leaf gives {ppn[21:10], va[21:0]}.
- R11: A fault response has rsp_fault set, rsp_cause = {page_fault, kind} (kind 0 fetch, 1 load, 2 store), rsp_tval equal to the virtual address, and rsp_paddr zero.
- R12: After reset the walker is ready and idle. Each read request lasts one cycle and is never followed by another before its response. A read and a write are never requested in the same cycle. req_ready stays low from acceptance until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted when both are high |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_smode | input | 1 | 1 supervisor, 0 user |
| req_sum | input | 1 | Supervisor may load and store user pages |
| req_mxr | input | 1 | Executable pages readable by loads |
| req_xlat_en | input | 1 | Translation enabled |
| req_root_ppn | input | 22 | Root table page number |
| mem_rd_valid | output | 1 | One-cycle entry read request |
| mem_rd_addr | output | 34 | Entry byte address |
| mem_rd_resp | input | 1 | Read response strobe |
| mem_rd_err | input | 1 | Address not backed by memory |
| mem_rd_data | input | 32 | Entry read |
| mem_wr_valid | output | 1 | One-cycle entry write request |
| mem_wr_addr | output | 34 | Entry byte address |
| mem_wr_data | output | 32 | Updated entry |
| mem_wr_ack | input | 1 | Write completed |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 3 | {page fault, kind} |
| rsp_paddr | output | 34 | Physical address |
| rsp_tval | output | 32 | Virtual address of the request |

## Verification
The assertions assume that memory answers each read exactly once, some cycles after the read request, and never without one. They also assume that a write acknowledge comes only after a write request. The bench memory model keeps to these rules: it answers every read after a fixed two-cycle latency, flags addresses at or above 1 GiB as not backed, and acknowledges each write on the following cycle. The bench drives only the three legal access kinds.

// File: rtl/ptw_pkg.sv
// Package: shared constants and types of the page table walker.
// Assumes a 32-bit entry with the flag bits in its low byte.
package ptw_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_kind_t;

    localparam int F_V = 0;
    localparam int F_R = 1;
    localparam int F_W = 2;
    localparam int F_X = 3;
    localparam int F_U = 4;
    localparam int F_A = 6;
    localparam int F_D = 7;
    localparam int PPN_LSB = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_WRITE,
        ST_WACK
    } walk_state_t;
endpackage

// File: rtl/ptw_addr_calc.sv
// Address arithmetic of the walker: the byte address of the entry for the
// current level and the physical address a leaf at that level yields.
// Assumes the physical address is at least as wide as the virtual one.
module ptw_addr_calc #(
    parameter int VA_W       = 32,
    parameter int PPN_W      = 22,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 10,
    parameter int PTE_SHIFT  = 2,
    parameter int LVL_W      = 1,
    localparam int PA_W      = PPN_W + PAGE_SHIFT
) (
    input  logic [VA_W-1:0]  va,
    input  logic [PPN_W-1:0] base_ppn,
    input  logic [LVL_W-1:0] level,
    input  logic [PPN_W-1:0] leaf_ppn,
    output logic [PA_W-1:0]  pte_addr,
    output logic [PA_W-1:0]  leaf_pa
);
    localparam logic [PA_W-1:0] IDX_MASK = PA_W'((1 << IDX_W) - 1);

    logic [PA_W-1:0] va_ext;
    logic [PA_W-1:0] idx;
    logic [PA_W-1:0] off_mask;
    int unsigned     shamt;

    // Index of this level and entry address inside the table.
    always_comb begin
        va_ext   = PA_W'(va);
        shamt    = PAGE_SHIFT + IDX_W * 32'(level);
        idx      = (va_ext >> shamt) & IDX_MASK;
        pte_addr = {base_ppn, {PAGE_SHIFT{1'b0}}} + (idx << PTE_SHIFT);
    end

    // Leaf address: high part from the entry, untranslated low bits from va.
    always_comb begin
        off_mask = (PA_W'(1) << shamt) - PA_W'(1);
        leaf_pa  = ({leaf_ppn, {PAGE_SHIFT{1'b0}}} & ~off_mask) | (va_ext & off_mask);
    end
endmodule

// File: rtl/ptw_leaf_check.sv
// Leaf entry checks: user-bit privilege rule, entry format, permission for
// the access kind and superpage alignment. Pure combinational.
// Assumes the entry passed in is not a pointer to a further table.
module ptw_leaf_check
    import ptw_pkg::*;
#(
    parameter int PPN_W = 22,
    parameter int IDX_W = 10,
    parameter int LVL_W = 1,
    localparam int PTE_W = PPN_W + PPN_LSB
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [1:0]       kind,
    input  logic             smode,
    input  logic             sum,
    input  logic             mxr,
    input  logic [LVL_W-1:0] level,
    output logic             page_fault
);
    logic v, r, w, x, u;
    logic priv_bad, fmt_bad, perm_bad, align_bad;
    logic [PPN_W-1:0] ppn;

    // Split the entry into its flags.
    always_comb begin
        v   = pte[F_V];
        r   = pte[F_R];
        w   = pte[F_W];
        x   = pte[F_X];
        u   = pte[F_U];
        ppn = pte[PTE_W-1:PPN_LSB];
    end

    // User-bit rule and malformed-entry rule.
    always_comb begin
        if (u) priv_bad = smode && (kind == ACC_FETCH || !sum);
        else   priv_bad = !smode;
        fmt_bad = !v || (w && !r);
    end

    // Permission needed by each access kind.
    always_comb begin
        unique case (kind)
            ACC_FETCH: perm_bad = !x;
            ACC_LOAD:  perm_bad = !(r || (mxr && x));
            ACC_STORE: perm_bad = !(r && w);
            default:   perm_bad = 1'b1;
        endcase
    end

    // A superpage must have its low page number bits clear.
    always_comb begin
        align_bad  = (ppn & ((PPN_W'(1) << (IDX_W * 32'(level))) - PPN_W'(1))) != '0;
        page_fault = priv_bad || fmt_bad || perm_bad || align_bad;
    end
endmodule

// File: rtl/ptw_walker.sv
// Two-level page table walker. Accepts one request at a time, reads one
// entry per level, checks the leaf, writes back A/D when needed and
// answers with a physical address or a classified fault.
// Assumes one memory response per read and a write acknowledge per write.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PPN_W      = 22,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 10,
    parameter int LEVELS     = 2,
    parameter int PTE_SHIFT  = 2,
    localparam int PA_W      = PPN_W + PAGE_SHIFT,
    localparam int PTE_W     = PPN_W + PPN_LSB,
    localparam int LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    input  logic             req_smode,
    input  logic             req_sum,
    input  logic             req_mxr,
    input  logic             req_xlat_en,
    input  logic [PPN_W-1:0] req_root_ppn,
    output logic             mem_rd_valid,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_resp,
    input  logic             mem_rd_err,
    input  logic [PTE_W-1:0] mem_rd_data,
    output logic             mem_wr_valid,
    output logic [PA_W-1:0]  mem_wr_addr,
    output logic [PTE_W-1:0] mem_wr_data,
    input  logic             mem_wr_ack,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [2:0]       rsp_cause,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [VA_W-1:0]  rsp_tval
);
    walk_state_t      st;
    logic [VA_W-1:0]  va_q;
    logic [1:0]       kind_q;
    logic             smode_q, sum_q, mxr_q;
    logic [LVL_W-1:0] level_q;
    logic [PPN_W-1:0] base_q;
    logic [PTE_W-1:0] new_pte_q;
    logic [PA_W-1:0]  pa_q;

    logic [PA_W-1:0]  pte_addr, leaf_pa;
    logic             leaf_fault, is_ptr;
    logic [PTE_W-1:0] upd_pte;

    ptw_addr_calc #(
        .VA_W(VA_W), .PPN_W(PPN_W), .PAGE_SHIFT(PAGE_SHIFT),
        .IDX_W(IDX_W), .PTE_SHIFT(PTE_SHIFT), .LVL_W(LVL_W)
    ) addr_i (
        .va(va_q), .base_ppn(base_q), .level(level_q),
        .leaf_ppn(mem_rd_data[PTE_W-1:PPN_LSB]),
        .pte_addr(pte_addr), .leaf_pa(leaf_pa)
    );

    ptw_leaf_check #(
        .PPN_W(PPN_W), .IDX_W(IDX_W), .LVL_W(LVL_W)
    ) check_i (
        .pte(mem_rd_data), .kind(kind_q), .smode(smode_q), .sum(sum_q),
        .mxr(mxr_q), .level(level_q), .page_fault(leaf_fault)
    );

    // Pointer detection and the entry with A (and D for a store) set.
    always_comb begin
        is_ptr  = mem_rd_data[F_V] && !mem_rd_data[F_R] && !mem_rd_data[F_W] && !mem_rd_data[F_X];
        upd_pte = mem_rd_data | (PTE_W'(1) << F_A)
                | ((kind_q == ACC_STORE) ? (PTE_W'(1) << F_D) : '0);
    end

    // Port drives derived from the walk state.
    always_comb begin
        req_ready    = (st == ST_IDLE);
        mem_rd_valid = (st == ST_READ);
        mem_rd_addr  = pte_addr;
        mem_wr_valid = (st == ST_WRITE);
        mem_wr_addr  = pte_addr;
        mem_wr_data  = new_pte_q;
    end

    // Walk sequencer and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            va_q      <= '0;
            kind_q    <= '0;
            smode_q   <= 1'b0;
            sum_q     <= 1'b0;
            mxr_q     <= 1'b0;
            level_q   <= '0;
            base_q    <= '0;
            new_pte_q <= '0;
            pa_q      <= '0;
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_cause <= '0;
            rsp_paddr <= '0;
            rsp_tval  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    va_q    <= req_vaddr;
                    kind_q  <= req_kind;
                    smode_q <= req_smode;
                    sum_q   <= req_sum;
                    mxr_q   <= req_mxr;
                    level_q <= LVL_W'(LEVELS - 1);
                    base_q  <= req_root_ppn;
                    if (req_xlat_en) begin
                        st <= ST_READ;
                    end else begin
                        rsp_valid <= 1'b1;
                        rsp_fault <= 1'b0;
                        rsp_cause <= '0;
                        rsp_paddr <= PA_W'(req_vaddr);
                        rsp_tval  <= req_vaddr;
                    end
                end
                ST_READ: st <= ST_WAIT;
                ST_WAIT: if (mem_rd_resp) begin
                    if (mem_rd_err || (is_ptr && level_q == '0) || (!is_ptr && leaf_fault)) begin
                        st        <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        rsp_fault <= 1'b1;
                        rsp_cause <= {!mem_rd_err, kind_q};
                        rsp_paddr <= '0;
                        rsp_tval  <= va_q;
                    end else if (is_ptr) begin
                        level_q <= level_q - 1'b1;
                        base_q  <= mem_rd_data[PTE_W-1:PPN_LSB];
                        st      <= ST_READ;
                    end else if (upd_pte != mem_rd_data) begin
                        new_pte_q <= upd_pte;
                        pa_q      <= leaf_pa;
                        st        <= ST_WRITE;
                    end else begin
                        st        <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        rsp_fault <= 1'b0;
                        rsp_cause <= '0;
                        rsp_paddr <= leaf_pa;
                        rsp_tval  <= va_q;
                    end
                end
                ST_WRITE: st <= ST_WACK;
                ST_WACK: if (mem_wr_ack) begin
                    st        <= ST_IDLE;
                    rsp_valid <= 1'b1;
                    rsp_fault <= 1'b0;
                    rsp_cause <= '0;
                    rsp_paddr <= pa_q;
                    rsp_tval  <= va_q;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R1: bypass answers on the next cycle with the zero-extended address.
    a_r1_bypass_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_xlat_en) |=>
            (rsp_valid && !rsp_fault && rsp_paddr == PA_W'($past(req_vaddr))));

    // R2: the first read of a walk lies in the root table.
    a_r2_first_read_in_root: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && $past(req_ready)) |->
            (mem_rd_addr[PA_W-1:PAGE_SHIFT] == $past(req_root_ppn)));

    // R4: an error response turns into an access fault.
    a_r4_err_access_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && mem_rd_resp && mem_rd_err) |=>
            (rsp_valid && rsp_fault && !rsp_cause[2]));

    // R9: every write-back carries A, and D for a store.
    a_r9_write_sets_a: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> mem_wr_data[F_A]);
    a_r9_store_sets_d: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && kind_q == ACC_STORE) |-> mem_wr_data[F_D]);

    // R11: a fault reports the request's virtual address and no address.
    a_r11_fault_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_tval == va_q && rsp_paddr == '0));

    // R12: single-cycle reads, and read and write never together.
    a_r12_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> !mem_rd_valid);
    a_r12_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_valid && mem_wr_valid));
endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_smode = 1'b0, req_sum = 1'b0, req_mxr = 1'b0, req_xlat_en = 1'b0;
    logic [21:0] req_root_ppn = '0;
    logic        mem_rd_valid;
    logic [33:0] mem_rd_addr;
    logic        mem_rd_resp = 1'b0, mem_rd_err = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        mem_wr_valid;
    logic [33:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        mem_wr_ack = 1'b0;
    logic        rsp_valid, rsp_fault;
    logic [2:0]  rsp_cause;
    logic [33:0] rsp_paddr;
    logic [31:0] rsp_tval;

    always #2 clk = ~clk;

    ptw_walker dut_i (.*);

    localparam logic [33:0] MEM_LIMIT = 34'h0_4000_0000;
    localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                           FU = 8'h10, FA = 8'h40, FD = 8'h80;
    localparam logic [21:0] ROOT = 22'h00100, L0T = 22'h00200, BAD = 22'h3F0000;

    logic [31:0] mem [logic [33:0]];
    int nchecks = 0, nfail = 0, nreads = 0, rpend = 0;
    logic [33:0] raddr;
    bit wpend = 0, got_w = 0;
    logic [33:0] got_waddr;
    logic [31:0] got_wdata;
    bit running = 0;

    function automatic logic [31:0] rdw(logic [33:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] mk(logic [21:0] ppn, logic [7:0] fl);
        return {ppn, 2'b00, fl};
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference of one translation against the current memory.
    task automatic ref_walk(input logic [31:0] va, input logic [1:0] kind,
                            input bit sm, input bit su, input bit mx, input bit xe,
                            input logic [21:0] root, output bit f, output bit pg,
                            output logic [33:0] pa, output bit wneed,
                            output logic [33:0] waddr, output logic [31:0] wdata);
        logic [21:0] base;
        f = 0; pg = 0; pa = '0; wneed = 0; waddr = '0; wdata = '0;
        if (!xe) begin pa = {2'b00, va}; return; end
        base = root;
        for (int lvl = 1; lvl >= 0; lvl--) begin
            logic [33:0] a;
            logic [31:0] d, nd;
            bit v, r, w, x, u, bad;
            a = {base, 12'h000} + 34'((va >> (12 + 10 * lvl)) & 32'h3FF) * 4;
            if (a >= MEM_LIMIT) begin f = 1; pg = 0; return; end
            d = rdw(a);
            v = d[0]; r = d[1]; w = d[2]; x = d[3]; u = d[4];
            if (v && !r && !w && !x) begin
                if (lvl == 0) begin f = 1; pg = 1; return; end
                base = d[31:10];
                continue;
            end
            bad = u ? (sm && (kind == 2'd0 || !su)) : !sm;
            if (!v || (w && !r)) bad = 1;
            if (kind == 2'd0 && !x) bad = 1;
            if (kind == 2'd1 && !(r || (mx && x))) bad = 1;
            if (kind == 2'd2 && !(r && w)) bad = 1;
            if (lvl == 1 && d[19:10] != 0) bad = 1;
            if (bad) begin f = 1; pg = 1; return; end
            pa = (lvl == 1) ? {d[31:20], va[21:0]} : {d[31:10], va[11:0]};
            nd = d | 32'h40 | ((kind == 2'd2) ? 32'h80 : 32'h0);
            wneed = (nd != d); waddr = a; wdata = nd;
            return;
        end
    endtask

    // Memory model: reads answered after two cycles, writes acknowledged after one.
    initial forever begin
        @(negedge clk);
        mem_rd_resp = 0; mem_rd_err = 0; mem_wr_ack = 0;
        if (rpend > 0) begin
            rpend--;
            if (rpend == 0) begin
                mem_rd_resp = 1;
                if (raddr >= MEM_LIMIT) begin mem_rd_err = 1; mem_rd_data = '0; end
                else mem_rd_data = rdw(raddr);
            end
        end
        if (wpend) begin wpend = 0; mem_wr_ack = 1; end
        if (mem_rd_valid) begin rpend = 2; raddr = mem_rd_addr; nreads++; end
        if (mem_wr_valid) begin
            got_w = 1; got_waddr = mem_wr_addr; got_wdata = mem_wr_data;
            mem[mem_wr_addr] = mem_wr_data; wpend = 1;
        end
        if (running && (mem_rd_valid || mem_wr_valid))
            chk("R12", "rd/wr overlap", 64'(mem_rd_valid && mem_wr_valid), 64'(0));
    end

    task automatic do_req(string tag, logic [31:0] va, logic [1:0] kind, bit sm,
                          bit su, bit mx, bit xe, logic [21:0] root);
        bit f, pg, wneed;
        logic [33:0] pa, waddr;
        logic [31:0] wdata;
        int cyc;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        ref_walk(va, kind, sm, su, mx, xe, root, f, pg, pa, wneed, waddr, wdata);
        nreads = 0; got_w = 0;
        req_vaddr = va; req_kind = kind; req_smode = sm; req_sum = su;
        req_mxr = mx; req_xlat_en = xe; req_root_ppn = root; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        cyc = 1;
        chk(tag, "R12 ready low after accept", 64'(req_ready || rsp_valid), 64'(rsp_valid));
        while (!rsp_valid && cyc < 100) begin @(negedge clk); cyc++; end
        chk(tag, "response seen", 64'(rsp_valid), 64'(1));
        chk(tag, "fault", 64'(rsp_fault), 64'(f));
        if (f) begin
            chk(tag, "R11 cause", 64'(rsp_cause), 64'({pg, kind}));
            chk(tag, "R11 tval", 64'(rsp_tval), 64'(va));
            chk(tag, "R11 paddr zero", 64'(rsp_paddr), 64'(0));
        end else begin
            chk(tag, "R10 paddr", 64'(rsp_paddr), 64'(pa));
        end
        chk(tag, "R9 write issued", 64'(got_w), 64'(wneed));
        if (wneed) begin
            chk(tag, "R9 write addr", 64'(got_waddr), 64'(waddr));
            chk(tag, "R9 write data", 64'(got_wdata), 64'(wdata));
        end
        if (!xe) begin
            chk(tag, "R1 latency", 64'(cyc), 64'(1));
            chk(tag, "R1 no read", 64'(nreads), 64'(0));
        end
    endtask

    task automatic set4k(logic [31:0] leaf);
        mem[34'h0_0010_0004] = mk(L0T, FV);
        mem[34'h0_0020_0004] = leaf;
    endtask

    localparam logic [31:0] VA4K = 32'h0040_1ABC, VASP = 32'h0081_2345;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R12", "reset ready", 64'(req_ready), 64'(1));
        chk("R12", "reset rsp_valid", 64'(rsp_valid), 64'(0));
        chk("R12", "reset rd_valid", 64'(mem_rd_valid), 64'(0));
        chk("R12", "reset wr_valid", 64'(mem_wr_valid), 64'(0));
        running = 1;

        do_req("R1 bypass", 32'hDEAD_BEEF, 2'd1, 1, 0, 0, 0, ROOT);
        do_req("R1 bypass fetch", 32'hFFFF_FFFC, 2'd0, 0, 0, 0, 0, BAD);

        set4k(mk(22'h12345, FV | FR | FW | FX | FA | FD));
        do_req("R2 R10 4k load no write", VA4K, 2'd1, 1, 0, 0, 1, ROOT);
        set4k(mk(22'h12345, FV | FR | FW));
        do_req("R9 store sets A D", VA4K, 2'd2, 1, 0, 0, 1, ROOT);
        set4k(mk(22'h12345, FV | FR | FW | FA));
        do_req("R9 store sets D only", VA4K, 2'd2, 1, 0, 0, 1, ROOT);

        mem[34'h0_0010_0008] = mk(22'h00C00, FV | FR | FU);
        do_req("R10 superpage user load", VASP, 2'd1, 0, 0, 0, 1, ROOT);
        mem[34'h0_0010_0008] = mk(22'h00C01, FV | FR | FA);
        do_req("R8 misaligned superpage", VASP, 2'd1, 1, 0, 0, 1, ROOT);

        set4k(mk(22'h00777, FV | FX | FU | FA));
        do_req("R5 S fetch of U page with SUM", VA4K, 2'd0, 1, 1, 0, 1, ROOT);
        set4k(mk(22'h00777, FV | FR | FU | FA));
        do_req("R5 S load of U page with SUM", VA4K, 2'd1, 1, 1, 0, 1, ROOT);
        do_req("R5 S load of U page no SUM", VA4K, 2'd1, 1, 0, 0, 1, ROOT);
        set4k(mk(22'h00777, FV | FR | FA));
        do_req("R5 user on S page", VA4K, 2'd1, 0, 0, 0, 1, ROOT);

        set4k(mk(22'h00777, FR | FW | FA));
        do_req("R6 V clear", VA4K, 2'd1, 1, 0, 0, 1, ROOT);
        set4k(mk(22'h00777, FV | FW | FX | FA));
        do_req("R6 W without R", VA4K, 2'd0, 1, 0, 0, 1, ROOT);

        set4k(mk(22'h00888, FV | FX | FA));
        do_req("R7 load X page MXR", VA4K, 2'd1, 1, 0, 1, 1, ROOT);
        do_req("R7 load X page no MXR", VA4K, 2'd1, 1, 0, 0, 1, ROOT);
        set4k(mk(22'h00888, FV | FR | FA));
        do_req("R7 store on R page", VA4K, 2'd2, 1, 0, 0, 1, ROOT);
        do_req("R7 fetch without X", VA4K, 2'd0, 1, 0, 0, 1, ROOT);

        do_req("R4 root unbacked", VA4K, 2'd2, 1, 0, 0, 1, BAD);
        mem[34'h0_0010_0004] = mk(BAD, FV);
        do_req("R4 second level unbacked", VA4K, 2'd0, 1, 0, 0, 1, ROOT);

        set4k(mk(22'h00300, FV));
        do_req("R3 pointer at last level", VA4K, 2'd1, 1, 0, 0, 1, ROOT);
        mem[34'h0_0010_0000] = 32'h0;
        do_req("R6 empty root entry", 32'h0000_0123, 2'd1, 1, 0, 0, 1, ROOT);

        running = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        nchecks++; nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    end
endmodule